// File: doc/BRIEF.md
# Encoder-Windowed Sample Integrator

This block sums a stream of signed ADC samples over windows set by shaft angle, not by time. A rotating-coil front end delivers one corrected sample per strobe. A position encoder fixes the window edges: an index (zero-angle) pulse arms the block, and every later encoder rising edge closes the current window and starts the next. Each closed window produces one result. The result holds the saturated sum of the offset-corrected samples and the number of samples that went into the sum. The sample count gives the window's duration to a resolution of one sample period.

Before accumulation, a stored calibration offset is subtracted from every sample. A run lasts for pulses-per-turn times number-of-turns windows and may span several revolutions without a break. The final result of a run is flagged. Converting the sums to physical flux units is left to downstream logic.

Top module: `angle_window_integrator`

## Requirements
- R1: The encoder and index pins each pass through a two-flop synchronizer and then a rising-edge detector. If a pin is first sampled high at clock edge k, the samples accepted at edges k and k+1 still belong to the old window, and the sample accepted at edge k+2 belongs to the new window. The result for the closed window is valid after edge k+2.
- R2: After `enable` rises, nothing is accumulated and no result is produced until an index rising edge arrives. Encoder edges before that point are ignored. Samples accepted from the index's effective cycle onward form the first window.
- R3: While running, each encoder rising edge produces exactly one result pulse. The pulse carries the sum and the count of the samples accepted since the previous window opened. A window with a nonzero sum always has a nonzero count.
- R4: Each accepted sample is reduced by the stored offset before it is added, as a signed difference of SAMPLE_W+1 bits. A `cal_load` pulse stores `cal_offset`, and the new value applies to samples from the next cycle onward. The stored offset resets to zero.
- R5: The sum is a signed value of SAMPLE_W+ACC_EXTRA bits. It clamps at its most positive and most negative values instead of wrapping. `res_ovf` reports whether any clamp happened in that window, even if later samples moved the sum back off the limit.
- R6: The sample count stops at its all-ones value instead of wrapping.
- R7: A run ends after `ppt`×`turns` results. The final result has `res_last` set. Further encoder edges give no result until `enable` has been low and the block has been re-armed.
- R8: If `ppt`×`turns` is zero, the block runs continuously and never sets `res_last`.
- R9: `enable` low aborts a run and discards the partial window, with no result. Afterwards a new index edge is required before any result.
- R10: After reset, `res_valid`, `res_sum` and `res_count` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run enable; low aborts and returns to idle |
| s_valid | input | 1 | Sample strobe |
| s_data | input | SAMPLE_W | Signed ADC sample |
| enc_pin | input | 1 | Encoder pulse, asynchronous |
| idx_pin | input | 1 | Index pulse, asynchronous |
| ppt | input | PPT_W | Encoder pulses per turn |
| turns | input | TURN_W | Number of turns per run |
| cal_load | input | 1 | Store `cal_offset` |
| cal_offset | input | SAMPLE_W | Signed offset correction |
| res_valid | output | 1 | One-cycle result strobe |
| res_sum | output | SAMPLE_W+ACC_EXTRA | Saturated signed window sum |
| res_count | output | CNT_W | Samples in the window (saturating) |
| res_ovf | output | 1 | Sum clamped during this window |
| res_last | output | 1 | Final result of the run |

## Verification
The bench builds the block with ACC_EXTRA=4, which makes the sum 22 bits wide. At that width a dozen full-scale corrected samples drive the sum into both clamps within a short window. CNT_W=6 lets a 70-sample window reach the count ceiling. PPT_W=4 and TURN_W=3 keep multi-turn runs, the last-result flag and the continuous zero-target mode to a few hundred cycles. The sample values differ from cycle to cycle, so a sample assigned to the wrong window at an encoder edge shows up as a wrong sum.

// File: rtl/awi_pkg.sv
package awi_pkg;

    localparam int unsigned DEF_SAMPLE_W  = 18;
    localparam int unsigned DEF_ACC_EXTRA = 20;
    localparam int unsigned DEF_CNT_W     = 16;
    localparam int unsigned DEF_PPT_W     = 16;
    localparam int unsigned DEF_TURN_W    = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_RUN,
        ST_DONE
    } win_state_e;

    // Per-cycle window control handed from the sequencer to the datapath
    typedef struct packed {
        logic open_w;   // first window opens (index edge)
        logic close_w;  // window closes and the next one opens
        logic last_w;   // the closing window is the final one
        logic active;   // accumulation allowed
    } win_ctl_t;

    function automatic logic rise_of(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

endpackage

// File: rtl/awi_edge_sync.sv
module awi_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise
);
    // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], pin};
    end

    assign rise = awi_pkg::rise_of(sh[STAGES-1], sh[STAGES]);
endmodule

// File: rtl/awi_window_ctrl.sv
module awi_window_ctrl
    import awi_pkg::*;
#(
    parameter int unsigned PPT_W  = DEF_PPT_W,
    parameter int unsigned TURN_W = DEF_TURN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              idx_rise,
    input  logic              enc_rise,
    input  logic [PPT_W-1:0]  ppt,
    input  logic [TURN_W-1:0] turns,
    output win_ctl_t          ctl
);
    localparam int unsigned TGT_W = PPT_W + TURN_W;

    win_state_e       st_q;
    logic [TGT_W-1:0] target;
    logic [TGT_W-1:0] win_q;
    logic [TGT_W-1:0] win_nx;

    assign target = TGT_W'(ppt) * TGT_W'(turns);
    assign win_nx = win_q + 1'b1;

    always_comb begin
        ctl.open_w  = enable && (st_q == ST_ARM) && idx_rise;
        ctl.close_w = enable && (st_q == ST_RUN) && enc_rise;
        ctl.active  = enable && (st_q == ST_RUN);
        ctl.last_w  = ctl.close_w && (target != '0) && (win_nx == target);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            win_q <= '0;
        end else if (!enable) begin
            st_q  <= ST_IDLE;
            win_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: st_q <= ST_ARM;
                ST_ARM: if (idx_rise) begin
                    st_q  <= ST_RUN;
                    win_q <= '0;
                end
                ST_RUN: if (ctl.close_w) begin
                    win_q <= win_nx;
                    if (ctl.last_w) st_q <= ST_DONE;
                end
                ST_DONE: st_q <= ST_DONE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/awi_accum.sv
module awi_accum
    import awi_pkg::*;
#(
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
    parameter int unsigned ACC_W    = DEF_SAMPLE_W + DEF_ACC_EXTRA,
    parameter int unsigned CNT_W    = DEF_CNT_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  win_ctl_t                   ctl,
    input  logic                       s_valid,
    input  logic signed [SAMPLE_W-1:0] s_data,
    input  logic                       cal_load,
    input  logic signed [SAMPLE_W-1:0] cal_offset,
    output logic                       res_valid,
    output logic signed [ACC_W-1:0]    res_sum,
    output logic [CNT_W-1:0]           res_count,
    output logic                       res_ovf,
    output logic                       res_last
);
    localparam int unsigned CORR_W = SAMPLE_W + 1;
    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [SAMPLE_W-1:0] off_q;
    logic signed [CORR_W-1:0]   corr;
    logic signed [ACC_W:0]      corr_x;
    logic signed [ACC_W:0]      sum_x;
    logic signed [ACC_W-1:0]    acc_q;
    logic signed [ACC_W-1:0]    acc_sat;
    logic [CNT_W-1:0]           cnt_q;
    logic                       ovf_q;
    logic                       clip_hi;
    logic                       clip_lo;

    // Offset-corrected sample, one bit wider than the input
    assign corr   = CORR_W'(s_data) - CORR_W'(off_q);
    assign corr_x = (ACC_W+1)'(corr);
    assign sum_x  = (ACC_W+1)'(acc_q) + corr_x;

    // The two top bits of the widened sum disagree on overflow
    assign clip_hi = !sum_x[ACC_W] &&  sum_x[ACC_W-1];
    assign clip_lo =  sum_x[ACC_W] && !sum_x[ACC_W-1];

    always_comb begin
        if (clip_hi)      acc_sat = ACC_MAX;
        else if (clip_lo) acc_sat = ACC_MIN;
        else              acc_sat = sum_x[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)           off_q <= '0;
        else if (cal_load) off_q <= cal_offset;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (ctl.open_w || ctl.close_w) begin
            // a sample in the boundary cycle opens the new window
            acc_q <= s_valid ? ACC_W'(corr) : '0;
            cnt_q <= s_valid ? CNT_W'(1) : '0;
            ovf_q <= 1'b0;
        end else if (ctl.active && s_valid) begin
            acc_q <= acc_sat;
            ovf_q <= ovf_q | clip_hi | clip_lo;
            if (!(&cnt_q)) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_sum   <= '0;
            res_count <= '0;
            res_ovf   <= 1'b0;
            res_last  <= 1'b0;
        end else begin
            res_valid <= ctl.close_w;
            res_last  <= ctl.last_w;
            if (ctl.close_w) begin
                res_sum   <= acc_q;
                res_count <= cnt_q;
                res_ovf   <= ovf_q;
            end
        end
    end
endmodule

// File: rtl/angle_window_integrator.sv
module angle_window_integrator
    import awi_pkg::*;
#(
    parameter int unsigned SAMPLE_W    = DEF_SAMPLE_W,
    parameter int unsigned ACC_EXTRA   = DEF_ACC_EXTRA,
    parameter int unsigned CNT_W       = DEF_CNT_W,
    parameter int unsigned PPT_W       = DEF_PPT_W,
    parameter int unsigned TURN_W      = DEF_TURN_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  enable,
    input  logic                                  s_valid,
    input  logic signed [SAMPLE_W-1:0]            s_data,
    input  logic                                  enc_pin,
    input  logic                                  idx_pin,
    input  logic [PPT_W-1:0]                      ppt,
    input  logic [TURN_W-1:0]                     turns,
    input  logic                                  cal_load,
    input  logic signed [SAMPLE_W-1:0]            cal_offset,
    output logic                                  res_valid,
    output logic signed [SAMPLE_W+ACC_EXTRA-1:0]  res_sum,
    output logic [CNT_W-1:0]                      res_count,
    output logic                                  res_ovf,
    output logic                                  res_last
);
    localparam int unsigned ACC_W  = SAMPLE_W + ACC_EXTRA;
    localparam int unsigned N_PINS = 2;   // 0: encoder, 1: index

    logic [N_PINS-1:0] pins;
    logic [N_PINS-1:0] rises;
    win_ctl_t          ctl;

    assign pins = {idx_pin, enc_pin};

    for (genvar g = 0; g < N_PINS; g++) begin : g_sync
        awi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .pin  (pins[g]),
            .rise (rises[g])
        );
    end

    awi_window_ctrl #(.PPT_W(PPT_W), .TURN_W(TURN_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .idx_rise (rises[1]),
        .enc_rise (rises[0]),
        .ppt      (ppt),
        .turns    (turns),
        .ctl      (ctl)
    );

    awi_accum #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .s_valid    (s_valid),
        .s_data     (s_data),
        .cal_load   (cal_load),
        .cal_offset (cal_offset),
        .res_valid  (res_valid),
        .res_sum    (res_sum),
        .res_count  (res_count),
        .res_ovf    (res_ovf),
        .res_last   (res_last)
    );
endmodule

// File: rtl/awi_checker.sv
module awi_checker #(
    parameter int unsigned ACC_W = 38,
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             enc_pin,
    input logic             res_valid,
    input logic             res_last,
    input logic [ACC_W-1:0] res_sum,
    input logic [CNT_W-1:0] res_count
);
    logic run_over_q;

    always_ff @(posedge clk) begin
        if (rst || !enable)         run_over_q <= 1'b0;
        else if (res_valid && res_last) run_over_q <= 1'b1;
    end

    // R1: a result follows a pin rise through two sync flops and one result flop
    p_enc_origin_r1: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ($past(enc_pin, 3) && !$past(enc_pin, 4)));

    // R3: a nonzero sum needs at least one sample
    p_sum_has_samples_r3: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_sum != '0) |-> (res_count != '0));

    // R7: the last flag only rides on a result
    p_last_with_valid_r7: assert property (@(posedge clk) disable iff (rst)
        res_last |-> res_valid);

    // R7: silence after the final result until re-enabled
    p_quiet_after_last_r7: assert property (@(posedge clk) disable iff (rst)
        run_over_q |-> !res_valid);

    // R9: no result follows a cycle with enable low
    p_no_result_disabled_r9: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !res_valid);
endmodule

bind angle_window_integrator awi_checker #(
    .ACC_W (SAMPLE_W + ACC_EXTRA),
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .enc_pin   (enc_pin),
    .res_valid (res_valid),
    .res_last  (res_last),
    .res_sum   (res_sum),
    .res_count (res_count)
);

// File: tb/angle_window_integrator_tb.sv
`timescale 1ns/1ps
module angle_window_integrator_tb;
    localparam int SAMPLE_W  = 18;
    localparam int ACC_EXTRA = 4;
    localparam int CNT_W     = 6;
    localparam int PPT_W     = 4;
    localparam int TURN_W    = 3;
    localparam int ACC_W     = SAMPLE_W + ACC_EXTRA;
    localparam longint SMAX  = (longint'(1) <<< (ACC_W-1)) - 1;
    localparam longint SMIN  = -(longint'(1) <<< (ACC_W-1));
    localparam int CMAX      = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic s_valid = 1'b0;
    logic signed [SAMPLE_W-1:0] s_data = '0;
    logic enc_pin = 1'b0;
    logic idx_pin = 1'b0;
    logic [PPT_W-1:0] ppt = '0;
    logic [TURN_W-1:0] turns = '0;
    logic cal_load = 1'b0;
    logic signed [SAMPLE_W-1:0] cal_offset = '0;
    logic res_valid;
    logic signed [ACC_W-1:0] res_sum;
    logic [CNT_W-1:0] res_count;
    logic res_ovf;
    logic res_last;

    always #10 clk = ~clk;

    angle_window_integrator #(
        .SAMPLE_W(SAMPLE_W), .ACC_EXTRA(ACC_EXTRA), .CNT_W(CNT_W),
        .PPT_W(PPT_W), .TURN_W(TURN_W)
    ) u_dut (
        .clk(clk), .rst(rst), .enable(enable), .s_valid(s_valid),
        .s_data(s_data), .enc_pin(enc_pin), .idx_pin(idx_pin),
        .ppt(ppt), .turns(turns), .cal_load(cal_load),
        .cal_offset(cal_offset), .res_valid(res_valid), .res_sum(res_sum),
        .res_count(res_count), .res_ovf(res_ovf), .res_last(res_last)
    );

    typedef struct {
        longint sum;
        int     cnt;
        bit     ovf;
        bit     last;
        string  tag;
    } exp_t;

    exp_t exp_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    string cur_tag = "R3";

    // bench model state
    int     m_st  = 0;
    longint m_acc = 0;
    int     m_cnt = 0;
    bit     m_ovf = 0;
    int     m_win = 0;
    longint m_off = 0;
    bit e1 = 0, e2 = 0, e3 = 0, i1 = 0, i2 = 0, i3 = 0;
    bit     ld_req = 0;
    longint ld_val = 0;

    function automatic void note(bit ok, string tag, string what, longint act, longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endfunction

    // One clock of stimulus plus the matching model update
    task automatic step(input bit en, input bit v, input longint d, input bit enc, input bit idx);
        bit er, ir, lst;
        longint corr, tgt;
        exp_t e;
        @(negedge clk);
        enable = en; s_valid = v; s_data = SAMPLE_W'(d);
        enc_pin = enc; idx_pin = idx;
        cal_load = ld_req; cal_offset = SAMPLE_W'(ld_val);
        er = e2 & ~e3;
        ir = i2 & ~i3;
        corr = d - m_off;
        tgt = longint'(ppt) * longint'(turns);
        if (!en) m_st = 0;
        else begin
            case (m_st)
                0: m_st = 1;
                1: if (ir) begin
                    m_st = 2; m_acc = v ? corr : 0; m_cnt = v ? 1 : 0; m_ovf = 0; m_win = 0;
                end
                2: if (er) begin
                    lst = (tgt != 0) && (longint'(m_win + 1) == tgt);
                    e.sum = m_acc; e.cnt = m_cnt; e.ovf = m_ovf; e.last = lst; e.tag = cur_tag;
                    exp_q.push_back(e);
                    m_win++;
                    if (lst) m_st = 3;
                    m_acc = v ? corr : 0; m_cnt = v ? 1 : 0; m_ovf = 0;
                end else if (v) begin
                    m_acc = m_acc + corr;
                    if (m_acc > SMAX) begin m_acc = SMAX; m_ovf = 1; end
                    if (m_acc < SMIN) begin m_acc = SMIN; m_ovf = 1; end
                    if (m_cnt < CMAX) m_cnt++;
                end
                default: ;
            endcase
        end
        e3 = e2; e2 = e1; e1 = enc;
        i3 = i2; i2 = i1; i1 = idx;
        if (ld_req) begin m_off = ld_val; ld_req = 0; end
    endtask

    task automatic load_offset(input longint o);
        ld_req = 1; ld_val = o;
        step(0, 0, 0, 0, 0);
        ld_req = 0;
    endtask

    task automatic index_pulse();
        step(1, 1, 11, 0, 1);
        step(1, 1, -5, 0, 1);
        step(1, 0, 0, 0, 0);
    endtask

    // len sample cycles; encoder high on the last one
    task automatic win(input int len, input longint base, input longint stride, input int gap);
        for (int i = 0; i < len; i++) begin
            step(1, (gap == 0) || (i % gap != 0), base + i * stride, i == len - 1, 0);
        end
    endtask

    task automatic drain(input bit en, input string tag);
        for (int i = 0; i < 6; i++) step(en, 0, 0, 0, 0);
        note(exp_q.size() == 0, tag, "pending expected results", exp_q.size(), 0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (exp_q.size() == 0) begin
                note(0, cur_tag, "unexpected result, sum", longint'(res_sum), 0);
            end else begin
                exp_t e;
                bit ok;
                e = exp_q.pop_front();
                ok = (longint'(res_sum) == e.sum) && (int'(res_count) == e.cnt) &&
                     (res_ovf == e.ovf) && (res_last == e.last);
                n_checks++;
                if (!ok) begin
                    n_fail++;
                    $display("FAIL %s result: actual sum=%0d cnt=%0d ovf=%0b last=%0b expected sum=%0d cnt=%0d ovf=%0b last=%0b",
                             e.tag, longint'(res_sum), res_count, res_ovf, res_last,
                             e.sum, e.cnt, e.ovf, e.last);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        note(0, "watchdog", "timeout", 0, 1);
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        note(res_valid == 1'b0, "R10", "res_valid after reset", res_valid, 0);
        note(res_sum == '0, "R10", "res_sum after reset", longint'(res_sum), 0);
        note(res_count == '0, "R10", "res_count after reset", res_count, 0);
        rst = 0;

        // R2 / R1 / R3 / R7: two turns of three pulses, encoder edges before index ignored
        cur_tag = "R2"; ppt = 3; turns = 2;
        step(1, 0, 0, 0, 0);
        win(5, 40, 1, 0);
        win(5, 40, 1, 0);
        drain(1, "R2");
        cur_tag = "R1_R3_R7";
        index_pulse();
        win(6, 1, 3, 0);
        win(7, -20, 5, 0);
        win(4, 1000, -300, 0);
        win(9, 7, 7, 0);
        win(5, -3, 2, 0);
        win(6, 100, 1, 0);
        cur_tag = "R7";
        win(6, 9, 1, 0);
        win(6, 9, 1, 0);
        drain(1, "R7");
        drain(0, "R7");

        // R4: stored offset with gapped samples
        cur_tag = "R4";
        load_offset(100);
        ppt = 2; turns = 1;
        step(1, 0, 0, 0, 0);
        index_pulse();
        win(8, 90, 4, 3);
        win(10, 500, -60, 3);
        drain(1, "R4");
        drain(0, "R4");

        // R5: positive clamp, then negative clamp
        cur_tag = "R5";
        load_offset(-131072);
        step(1, 0, 0, 0, 0);
        index_pulse();
        win(12, 131071, 0, 0);
        win(3, 2, 1, 0);
        drain(1, "R5");
        drain(0, "R5");
        load_offset(131071);
        step(1, 0, 0, 0, 0);
        index_pulse();
        win(12, -131072, 0, 0);
        win(4, 131071, -1, 0);
        drain(1, "R5");
        drain(0, "R5");

        // R6: count ceiling
        cur_tag = "R6";
        load_offset(0);
        ppt = 1; turns = 1;
        step(1, 0, 0, 0, 0);
        index_pulse();
        win(70, 1, 0, 0);
        drain(1, "R6");
        drain(0, "R6");

        // R8: zero target runs on without a last flag; R9 abort and re-arm
        cur_tag = "R8";
        ppt = 5; turns = 0;
        step(1, 0, 0, 0, 0);
        index_pulse();
        win(5, 3, 2, 0);
        win(6, -8, 3, 0);
        win(4, 50, 0, 0);
        win(7, 1, 1, 2);
        cur_tag = "R9";
        for (int i = 0; i < 4; i++) step(1, 1, 77, 0, 0);
        step(0, 1, 5, 1, 0);
        step(0, 0, 0, 0, 0);
        drain(0, "R9");
        win(5, 10, 1, 0);
        win(5, 10, 1, 0);
        drain(1, "R9");
        index_pulse();
        win(5, 21, 2, 0);
        win(5, 30, -4, 0);
        drain(1, "R9");
        drain(0, "R9");

        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule